// File: doc/BRIEF.md
# Phase-Modulated Oscillator Phase Path

This block produces the phase address stream for a numerically controlled oscillator. A wide phase accumulator advances by a frequency step word on every clock and wraps modulo 2^ACC_W with no clear. A phase offset word is added to the accumulator value, and the sum is cut down to its upper ADDR_W bits to address a sine table placed downstream. The bits below the address are kept inside the accumulator, so a fine frequency step still moves the address over time.

The frequency, offset and amplitude words are captured into holding registers on each clock. They can be changed at any time. Because the accumulator is never cleared, a frequency change bends the phase ramp without a jump. An offset change shifts the phase by exactly the new offset. The amplitude word is delayed so that it reaches the lookup stage in the same cycle as the address it belongs to.

A small sequencer runs after a synchronous reset. It uses three named states:
- ST_IDLE is entered on reset.
- ST_FILL is entered on the first clock after reset is released, while the pipeline fills.
- ST_RUN is entered on the next clock and is kept until the next reset.

The transitions are IDLE→FILL, FILL→RUN and RUN→RUN, and reset leads from any state to IDLE. The valid strobe is high only in ST_RUN.

Top module: `nco_phase_path`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `phase_addr` is 0, `amp_out` is 0 and `valid` is 0. The accumulator and all holding registers are also cleared to 0.
- R2: After `rst` falls, `valid` stays 0 after the first clock edge and becomes 1 after the second. It then stays 1 until the next reset.
- R3: The accumulator adds the captured frequency word on every clock and wraps modulo 2^ACC_W. `phase_addr` is bits [ACC_W-1 : ACC_W-ADDR_W] of the offset sum.
- R4: A frequency word driven before clock edge n+1 is captured at that edge. The address step between the values seen after edges n+1 and n+2 still uses the old word. The step seen after edge n+3 uses the new word.
- R5: A phase offset word driven before clock edge n+1 is fully included in `phase_addr` after edge n+2.
- R6: Changing the frequency word never clears or rewinds the accumulator. Every address step equals either the old step or the new step.
- R7: Frequency bits below the address field are accumulated. A step of 2^(ACC_W-ADDR_W-2) advances `phase_addr` by exactly 1 every 4 clocks.
- R8: The offset sum wraps modulo 2^ACC_W. An offset of 2^(ACC_W-1) moves `phase_addr` by half of its range, and an all-ones offset acts as minus one.
- R9: `amp_out` equals the `amp_word` value from two clock edges earlier. This keeps it aligned with the address that includes an offset driven at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | ACC_W | Phase step added per clock |
| phase_word | input | ACC_W | Phase offset added before truncation |
| amp_word | input | AMP_W | Amplitude scale for the lookup stage |
| phase_addr | output | ADDR_W | Truncated phase address |
| amp_out | output | AMP_W | Amplitude scale aligned with the address |
| valid | output | 1 | High once the pipeline holds live data |

## Verification
The hardest situation to reach is a frequency change that lands while the old and new steps are both still in the pipeline. Seen from the ports, that moment is only visible as the exact cycle in which the address step switches. The stimulus drives a new word on a falling edge and then examines the deltas of three consecutive addresses, which exposes any off-by-one in latency and any rewind of the accumulator. Fractional accumulation is reached with a step that lies wholly below the address field. The bench counts how often the address increments across a fixed window.

// File: rtl/nco_pkg.sv
package nco_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

    localparam int AMP_STAGES = 2;

endpackage

// File: rtl/nco_word_capture.sv
module nco_word_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] acc
);

    // wraps freely modulo 2^ACC_W; only reset clears it
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else begin
            acc <= acc + step;
        end
    end

endmodule

// File: rtl/nco_offset_trunc.sv
module nco_offset_trunc #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  acc,
    input  logic [ACC_W-1:0]  ofs,
    output logic [ACC_W-1:0]  sum,
    output logic [ADDR_W-1:0] addr
);

    localparam int TOP = ACC_W - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
        end else begin
            sum <= acc + ofs;
        end
    end

    assign addr = sum[TOP -: ADDR_W];

endmodule

// File: rtl/nco_seq_ctrl.sv
module nco_seq_ctrl
    import nco_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    output seq_state_t state,
    output logic       valid
);

    seq_state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = ST_FILL;
            ST_FILL: state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        valid = 1'b0;
        unique case (state)
            ST_IDLE: valid = 1'b0;
            ST_FILL: valid = 1'b0;
            ST_RUN:  valid = 1'b1;
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/nco_phase_path.sv
module nco_phase_path
    import nco_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  freq_word,
    input  logic [ACC_W-1:0]  phase_word,
    input  logic [AMP_W-1:0]  amp_word,
    output logic [ADDR_W-1:0] phase_addr,
    output logic [AMP_W-1:0]  amp_out,
    output logic              valid
);

    logic [ACC_W-1:0] freq_q;
    logic [ACC_W-1:0] ofs_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum_q;
    seq_state_t       state;
    logic [AMP_W-1:0] amp_pipe [AMP_STAGES+1];

    nco_word_capture #(.W(ACC_W)) i_freq_cap (
        .clk(clk), .rst(rst), .d(freq_word), .q(freq_q)
    );

    nco_word_capture #(.W(ACC_W)) i_ofs_cap (
        .clk(clk), .rst(rst), .d(phase_word), .q(ofs_q)
    );

    // amplitude delay line matches the offset-to-address latency
    assign amp_pipe[0] = amp_word;
    generate
        for (genvar g = 0; g < AMP_STAGES; g++) begin : g_amp
            nco_word_capture #(.W(AMP_W)) i_amp_cap (
                .clk(clk), .rst(rst), .d(amp_pipe[g]), .q(amp_pipe[g+1])
            );
        end
    endgenerate
    assign amp_out = amp_pipe[AMP_STAGES];

    nco_phase_acc #(.ACC_W(ACC_W)) i_acc (
        .clk(clk), .rst(rst), .step(freq_q), .acc(acc_q)
    );

    nco_offset_trunc #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) i_trunc (
        .clk(clk), .rst(rst), .acc(acc_q), .ofs(ofs_q),
        .sum(sum_q), .addr(phase_addr)
    );

    nco_seq_ctrl i_seq (
        .clk(clk), .rst(rst), .state(state), .valid(valid)
    );

endmodule

// File: rtl/nco_phase_path_chk.sv
module nco_phase_path_chk #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              valid,
    input logic [AMP_W-1:0]  amp_word,
    input logic [AMP_W-1:0]  amp_out,
    input logic [ADDR_W-1:0] phase_addr,
    input logic [ACC_W-1:0]  acc_q,
    input logic [ACC_W-1:0]  freq_q,
    input logic [ACC_W-1:0]  ofs_q,
    input logic [ACC_W-1:0]  sum_q
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (phase_addr == '0 && amp_out == '0 && !valid)); // R1

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid); // R2

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> (!$past(rst, 1) && !$past(rst, 2) && $past(rst, 3))); // R2

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        valid |-> acc_q == $past(acc_q) + $past(freq_q)); // R3

    AST_OFFSET_SUM: assert property (@(posedge clk) disable iff (rst)
        valid |-> sum_q == $past(acc_q) + $past(ofs_q)); // R8

    AST_AMP_ALIGN: assert property (@(posedge clk) disable iff (rst)
        valid |-> amp_out == $past(amp_word, 2)); // R9

endmodule

bind nco_phase_path nco_phase_path_chk #(
    .ACC_W(ACC_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W)
) i_chk (
    .clk(clk), .rst(rst), .valid(valid), .amp_word(amp_word),
    .amp_out(amp_out), .phase_addr(phase_addr), .acc_q(acc_q),
    .freq_q(freq_q), .ofs_q(ofs_q), .sum_q(sum_q)
);

// File: tb/test_nco_phase_path.sv
module test_nco_phase_path;

    localparam int ACC_W  = 32;
    localparam int ADDR_W = 8;
    localparam int AMP_W  = 8;
    localparam int CLK_NS = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ACC_W-1:0]  freq_word = '0;
    logic [ACC_W-1:0]  phase_word = '0;
    logic [AMP_W-1:0]  amp_word = '0;
    logic [ADDR_W-1:0] phase_addr;
    logic [AMP_W-1:0]  amp_out;
    logic              valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    nco_phase_path #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W)) i_nco_phase_path (
        .clk(clk), .rst(rst), .freq_word(freq_word), .phase_word(phase_word),
        .amp_word(amp_word), .phase_addr(phase_addr), .amp_out(amp_out), .valid(valid)
    );

    // reference model built from the stated latencies (R3, R4, R5, R9)
    logic [ACC_W-1:0] m_f, m_p, m_acc, m_sum;
    logic [AMP_W-1:0] m_a1, m_amp;
    int               m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            m_f <= '0; m_p <= '0; m_acc <= '0; m_sum <= '0;
            m_a1 <= '0; m_amp <= '0; m_cnt <= 0;
        end else begin
            m_f   <= freq_word;
            m_p   <= phase_word;
            m_acc <= m_acc + m_f;
            m_sum <= m_acc + m_p;
            m_a1  <= amp_word;
            m_amp <= m_a1;
            m_cnt <= (m_cnt < 2) ? m_cnt + 1 : 2;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step_model(input string tag);
        @(negedge clk);
        chk(tag, phase_addr, m_sum[ACC_W-1 -: ADDR_W], "phase_addr");
        chk(tag, valid, (m_cnt == 2), "valid");
        chk(tag, amp_out, m_amp, "amp_out");
    endtask

    task automatic do_reset(input logic [ACC_W-1:0] f, input logic [ACC_W-1:0] p);
        @(negedge clk);
        rst = 1'b1;
        freq_word = f; phase_word = p; amp_word = 8'h5A;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", phase_addr, 0, "addr in reset");
            chk("R1", amp_out, 0, "amp in reset");
            chk("R1", valid, 0, "valid in reset");
        end
        rst = 1'b0;
    endtask

    task automatic t_reset_valid;
        do_reset(32'h0100_0000, '0);
        @(negedge clk);
        chk("R2", valid, 0, "valid after 1st edge");
        @(negedge clk);
        chk("R2", valid, 1, "valid after 2nd edge");
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R2", valid, 1, "valid held");
        end
    endtask

    task automatic t_const_wrap;
        logic [ADDR_W-1:0] prev;
        do_reset(32'h0100_0000, '0);
        for (int i = 0; i < 3; i++) step_model("R3");
        prev = phase_addr;
        for (int i = 0; i < 300; i++) begin
            step_model("R3");
            chk("R3", phase_addr, ADDR_W'(prev + 1), "unit step with wrap");
            prev = phase_addr;
        end
        freq_word = 32'hF000_0000;
        for (int i = 0; i < 40; i++) step_model("R3");
    endtask

    task automatic t_low_bits;
        logic [ADDR_W-1:0] start;
        do_reset(32'h0040_0000, '0);
        for (int i = 0; i < 3; i++) step_model("R7");
        start = phase_addr;
        for (int i = 0; i < 16; i++) step_model("R7");
        chk("R7", phase_addr, ADDR_W'(start + 4), "addr after 16 fractional steps");
    endtask

    task automatic t_live_freq;
        logic [ADDR_W-1:0] a0, a1, a2, a3;
        do_reset(32'h0100_0000, '0);
        for (int i = 0; i < 5; i++) step_model("R4");
        a0 = phase_addr;
        freq_word = 32'h0300_0000;
        step_model("R4"); a1 = phase_addr;
        step_model("R4"); a2 = phase_addr;
        step_model("R4"); a3 = phase_addr;
        chk("R4", ADDR_W'(a1 - a0), 1, "step after n+1");
        chk("R6", ADDR_W'(a2 - a1), 1, "step after n+2");
        chk("R4", ADDR_W'(a3 - a2), 3, "step after n+3");
        for (int i = 0; i < 6; i++) begin
            step_model("R6");
            chk("R6", ADDR_W'(phase_addr - a3), 3, "continuous new step");
            a3 = phase_addr;
        end
    endtask

    task automatic t_phase_amp;
        logic [ADDR_W-1:0] a0;
        do_reset(32'h0100_0000, '0);
        for (int i = 0; i < 5; i++) step_model("R5");
        a0 = phase_addr;
        phase_word = 32'h8000_0000;
        amp_word = 8'hC3;
        step_model("R5");
        chk("R5", phase_addr, ADDR_W'(a0 + 1), "no offset yet after n+1");
        chk("R9", amp_out, 8'h5A, "old amp after n+1");
        step_model("R5");
        chk("R8", phase_addr, ADDR_W'(a0 + 2 + 128), "half-range offset after n+2");
        chk("R9", amp_out, 8'hC3, "new amp after n+2");
        a0 = phase_addr;
        phase_word = 32'hFFFF_FFFF;
        step_model("R8");
        step_model("R8");
        chk("R8", phase_addr, ADDR_W'(a0 + 2 - 128 - 1), "all-ones offset acts as minus one");
        for (int i = 0; i < 20; i++) begin
            amp_word = AMP_W'(i * 37);
            phase_word = 32'h1234_5678 * (i + 1);
            step_model("R9");
        end
    endtask

    initial begin
        t_reset_valid;
        t_const_wrap;
        t_low_bits;
        t_live_freq;
        t_phase_amp;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule